// File: doc/BRIEF.md
# Event-Selected Performance Counter Bank

This block holds six 32-bit performance counters for a processor core. Each clock it receives the number of instructions that retired in that cycle (0 to 7 with the default width). From two control words it decides which counters add that number, which add one for the elapsed cycle, and which hold. Counters 1 to 4 take their event from an 8-bit selector each. Counter 5 always counts instructions and counter 6 always counts cycles. Three freeze bits stop all counters, counters 1 to 4, or counters 5 and 6.

When a counter's advance reaches the negative half of its range and the matching overflow-enable bit is set, the counter stops at exactly `0x8000_0000` and raises a flag for one cycle. Without that enable the counter wraps silently. Software reaches all eight registers through a plain single-cycle register port. Writes take effect at the clock edge and reads are combinational.

Top module: `perf_counter_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every counter reads 0, control word 1 reads 0 and overflow flags are clear. Control word 0 reads `0x0000_0001`, so the bank starts globally frozen.
- R2: Register address 0..5 selects counters 1..6, address 6 selects control word 0 and address 7 selects control word 1. A write lands at the clock edge where `reg_we` is high. `reg_rdata` shows the addressed register combinationally.
- R3: In control word 0, bit 0 freezes all counters, bit 1 freezes counters 1 to 4 and bit 2 freezes counters 5 and 6. A frozen counter keeps its value and raises no overflow.
- R4: Control word 1 holds the selector for counter 1 in bits [7:0], counter 2 in [15:8], counter 3 in [23:16] and counter 4 in [31:24]. When the whole word is zero, counters 1 to 4 hold.
- R5: Counter 1 counts instructions for selector `0x02` or `0xFE` and counts cycles for `0x1E` or `0xF0`. Any other selector leaves it idle.
- R6: Counters 2 and 3 count instructions for `0x02` and cycles for `0x1E`. Any other selector, including `0xFE` and `0xF0`, leaves them idle.
- R7: Counter 4 counts instructions for `0x02` and cycles for `0x1E`. With `0xFA` it counts instructions only in cycles where `run_latch` is high.
- R8: When not frozen, counter 5 counts instructions and counter 6 advances by one every clock.
- R9: An instruction counter adds the full `retired` value in one clock and does not advance when `retired` is 0. A cycle counter adds exactly 1 per clock.
- R10: If an advance makes a counter reach or pass `0x8000_0000`, including by carry out of bit 31, and its enable is set, the counter becomes exactly `0x8000_0000`. Its bit in `ovf_vec` (bit i for counter i+1) and `ovf_pulse` are high in the following cycle. Counter 1 uses control word 0 bit 3 as its enable, and counters 2 to 6 share bit 4. A saturated counter raises the flag again every clock in which it advances.
- R11: With its enable clear, a counter wraps modulo 2^32 and raises no overflow.
- R12: A register write to a counter replaces that clock's advance, and that counter raises no overflow for that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retired | input | RET_W | Instructions retired this clock |
| run_latch | input | 1 | Run indication that gates selector `0xFA` on counter 4 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Addressed register contents |
| ovf_vec | output | 6 | Per-counter overflow flags, one cycle |
| ovf_pulse | output | 1 | OR of the overflow flags |

## Verification
A software write to a counter and that counter's own increment can land on the same clock edge, and that collision sits right next to the overflow threshold. The bench keeps counter 5 counting with its overflow enable set, writes `0x7FFF_FFFF` into it on a counting clock, and checks that the written value survives with no flag raised. It then checks that the next clock saturates the counter and raises the flag, and that the clock after that raises the flag again while the value holds at the threshold.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
    localparam int NCTR  = 6;
    localparam int SEL_W = 8;

    // control word 0 bit positions
    localparam int FRZ_ALL_BIT = 0;
    localparam int FRZ_LO_BIT  = 1;
    localparam int FRZ_HI_BIT  = 2;
    localparam int OVE_C1_BIT  = 3;
    localparam int OVE_REST_BIT = 4;

    // event selector codes
    localparam logic [SEL_W-1:0] EV_INS      = 8'h02;
    localparam logic [SEL_W-1:0] EV_CYC      = 8'h1E;
    localparam logic [SEL_W-1:0] EV_C1_INS2  = 8'hFE;
    localparam logic [SEL_W-1:0] EV_C1_CYC2  = 8'hF0;
    localparam logic [SEL_W-1:0] EV_C4_RUN   = 8'hFA;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_INS  = 2'd1,
        KIND_CYC  = 2'd2
    } cnt_kind_e;
endpackage

// File: rtl/pcb_event_decode.sv
`timescale 1ns/1ps
module pcb_event_decode #(
    parameter int CNT_W = 32
) (
    input  logic                                    frz_all,
    input  logic                                    frz_lo,
    input  logic                                    frz_hi,
    input  logic [CNT_W-1:0]                        ctrl1,
    input  logic                                    run_latch,
    output pcb_pkg::cnt_kind_e [pcb_pkg::NCTR-1:0]  kind
);
    import pcb_pkg::*;

    localparam int NLO = 4;

    logic [NLO-1:0][SEL_W-1:0] sel;
    logic lo_on;
    logic hi_on;

    for (genvar k = 0; k < NLO; k++) begin : g_sel
        assign sel[k] = ctrl1[k*SEL_W +: SEL_W];
    end

    assign lo_on = !frz_all && !frz_lo && (ctrl1 != '0);
    assign hi_on = !frz_all && !frz_hi;

    always_comb begin
        for (int i = 0; i < NCTR; i++) begin
            kind[i] = KIND_IDLE;
        end
        if (lo_on) begin
            // counter 1: two codes per kind
            if (sel[0] == EV_INS || sel[0] == EV_C1_INS2) begin
                kind[0] = KIND_INS;
            end else if (sel[0] == EV_CYC || sel[0] == EV_C1_CYC2) begin
                kind[0] = KIND_CYC;
            end
            // counters 2 and 3: base codes only
            for (int k = 1; k < 3; k++) begin
                if (sel[k] == EV_INS) begin
                    kind[k] = KIND_INS;
                end else if (sel[k] == EV_CYC) begin
                    kind[k] = KIND_CYC;
                end
            end
            // counter 4: gated alternate instruction code
            if (sel[3] == EV_INS || (sel[3] == EV_C4_RUN && run_latch)) begin
                kind[3] = KIND_INS;
            end else if (sel[3] == EV_CYC) begin
                kind[3] = KIND_CYC;
            end
        end
        if (hi_on) begin
            kind[4] = KIND_INS;
            kind[5] = KIND_CYC;
        end
    end
endmodule

// File: rtl/pcb_counter_slice.sv
`timescale 1ns/1ps
module pcb_counter_slice #(
    parameter int CNT_W = 32,
    parameter int RET_W = 3
) (
    input  logic [CNT_W-1:0]    cur,
    input  pcb_pkg::cnt_kind_e  kind,
    input  logic [RET_W-1:0]    retired,
    input  logic                ovf_en,
    input  logic                wr_hit,
    input  logic [CNT_W-1:0]    wdata,
    output logic [CNT_W-1:0]    nxt,
    output logic                ovf
);
    import pcb_pkg::*;

    localparam logic [CNT_W:0] THRESH = (CNT_W+1)'(1) << (CNT_W-1);

    logic [CNT_W-1:0] delta;
    logic [CNT_W:0]   sum;

    always_comb begin
        case (kind)
            KIND_INS: delta = CNT_W'(retired);
            KIND_CYC: delta = CNT_W'(1);
            default:  delta = '0;
        endcase
    end

    assign sum = {1'b0, cur} + {1'b0, delta};

    always_comb begin
        nxt = cur;
        ovf = 1'b0;
        if (wr_hit) begin
            nxt = wdata;
        end else if (delta != '0) begin
            if (ovf_en && sum >= THRESH) begin
                nxt = THRESH[CNT_W-1:0];
                ovf = 1'b1;
            end else begin
                nxt = sum[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank #(
    parameter int CNT_W  = 32,
    parameter int RET_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RET_W-1:0]           retired,
    input  logic                       run_latch,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [CNT_W-1:0]           reg_wdata,
    output logic [CNT_W-1:0]           reg_rdata,
    output logic [pcb_pkg::NCTR-1:0]   ovf_vec,
    output logic                       ovf_pulse
);
    import pcb_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_CTRL0 = ADDR_W'(NCTR);
    localparam logic [ADDR_W-1:0] ADDR_CTRL1 = ADDR_W'(NCTR + 1);
    localparam logic [CNT_W-1:0]  CTRL0_RST  = CNT_W'(1) << FRZ_ALL_BIT;

    typedef struct packed {
        logic [NCTR-1:0][CNT_W-1:0] cnt;
        logic [CNT_W-1:0]           ctrl0;
        logic [CNT_W-1:0]           ctrl1;
        logic [NCTR-1:0]            ovf;
    } bank_state_t;

    bank_state_t s_q, s_d;

    cnt_kind_e [NCTR-1:0]        kind;
    logic [NCTR-1:0][CNT_W-1:0]  slice_nxt;
    logic [NCTR-1:0]             slice_ovf;

    pcb_event_decode #(.CNT_W(CNT_W)) u_decode (
        .frz_all   (s_q.ctrl0[FRZ_ALL_BIT]),
        .frz_lo    (s_q.ctrl0[FRZ_LO_BIT]),
        .frz_hi    (s_q.ctrl0[FRZ_HI_BIT]),
        .ctrl1     (s_q.ctrl1),
        .run_latch (run_latch),
        .kind      (kind)
    );

    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
        logic ove;
        logic hit;
        if (i == 0) begin : g_own_en
            assign ove = s_q.ctrl0[OVE_C1_BIT];
        end else begin : g_shared_en
            assign ove = s_q.ctrl0[OVE_REST_BIT];
        end
        assign hit = reg_we && (reg_addr == ADDR_W'(i));

        pcb_counter_slice #(.CNT_W(CNT_W), .RET_W(RET_W)) u_slice (
            .cur     (s_q.cnt[i]),
            .kind    (kind[i]),
            .retired (retired),
            .ovf_en  (ove),
            .wr_hit  (hit),
            .wdata   (reg_wdata),
            .nxt     (slice_nxt[i]),
            .ovf     (slice_ovf[i])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.cnt = slice_nxt;
        s_d.ovf = slice_ovf;
        if (reg_we && reg_addr == ADDR_CTRL0) begin
            s_d.ctrl0 = reg_wdata;
        end
        if (reg_we && reg_addr == ADDR_CTRL1) begin
            s_d.ctrl1 = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.ctrl0 <= CTRL0_RST;
            s_q.ctrl1 <= '0;
            s_q.ovf   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL0) begin
            reg_rdata = s_q.ctrl0;
        end else if (reg_addr == ADDR_CTRL1) begin
            reg_rdata = s_q.ctrl1;
        end else begin
            for (int i = 0; i < NCTR; i++) begin
                if (reg_addr == ADDR_W'(i)) begin
                    reg_rdata = s_q.cnt[i];
                end
            end
        end
    end

    assign ovf_vec   = s_q.ovf;
    assign ovf_pulse = |s_q.ovf;
endmodule

// File: rtl/pcb_bank_checker.sv
`timescale 1ns/1ps
module pcb_bank_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_we,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic [CNT_W-1:0]                    reg_wdata,
    input logic [pcb_pkg::NCTR*CNT_W-1:0]      cnt_flat,
    input logic [CNT_W-1:0]                    ctrl0,
    input logic [CNT_W-1:0]                    ctrl1,
    input logic [pcb_pkg::NCTR-1:0]            ovf_vec
);
    import pcb_pkg::*;

    localparam logic [CNT_W-1:0] THR = CNT_W'(1) << (CNT_W-1);
    localparam int LO_W = 4 * CNT_W;

    logic cnt_written;
    logic lo_written;
    assign cnt_written = reg_we && (reg_addr < ADDR_W'(NCTR));
    assign lo_written  = reg_we && (reg_addr < ADDR_W'(4));

    // R3: global freeze holds every counter and blocks overflow
    p_freeze_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0[FRZ_ALL_BIT] && !cnt_written) |=> ($stable(cnt_flat) && ovf_vec == '0));

    // R4: zero selector word idles counters 1..4
    p_grp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1 == '0 && !lo_written) |=> ($stable(cnt_flat[LO_W-1:0]) && ovf_vec[3:0] == '0));

    // R8: counter 6 steps by one when running without overflow enable
    p_cyc6_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl0[FRZ_ALL_BIT] && !ctrl0[FRZ_HI_BIT] && !ctrl0[OVE_REST_BIT]
         && !(reg_we && reg_addr == ADDR_W'(5)))
        |=> (cnt_flat[5*CNT_W +: CNT_W] == $past(cnt_flat[5*CNT_W +: CNT_W]) + CNT_W'(1)));

    for (genvar i = 0; i < NCTR; i++) begin : g_chk
        // R10: a raised flag means the counter sits at the threshold
        p_ovf_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_vec[i] |-> (cnt_flat[i*CNT_W +: CNT_W] == THR));

        // R12: a software write wins over the same-cycle advance
        p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(i))
            |=> (cnt_flat[i*CNT_W +: CNT_W] == $past(reg_wdata) && !ovf_vec[i]));
    end
endmodule

bind perf_counter_bank pcb_bank_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_flat  (s_q.cnt),
    .ctrl0     (s_q.ctrl0),
    .ctrl1     (s_q.ctrl1),
    .ovf_vec   (s_q.ovf)
);

// File: tb/perf_counter_bank_tb.sv
`timescale 1ns/1ps
module perf_counter_bank_tb;
    localparam int CNT_W  = 32;
    localparam int RET_W  = 3;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RET_W-1:0]  retired = '0;
    logic              run_latch = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [CNT_W-1:0]  reg_wdata = '0;
    logic [CNT_W-1:0]  reg_rdata;
    logic [5:0]        ovf_vec;
    logic              ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    perf_counter_bank #(.CNT_W(CNT_W), .RET_W(RET_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .retired(retired), .run_latch(run_latch),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_vec(ovf_vec), .ovf_pulse(ovf_pulse)
    );

    typedef struct packed {
        logic [31:0] c0;
        logic [31:0] c1;
        logic        run;
        logic [2:0]  ret;
        logic [31:0] start;
        logic [5:0]  ovf;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [31:0] e3;
        logic [31:0] e4;
        logic [31:0] e5;
        logic [31:0] e6;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R5 R6 R7 R8 R9: mixed instruction and cycle selectors
        '{32'h0, 32'h1E021E02, 1'b0, 3'd5, 32'd100, 6'b0, 32'd105, 32'd101, 32'd105, 32'd101, 32'd105, 32'd101},
        // R4: selector word zero
        '{32'h0, 32'h0, 1'b0, 3'd3, 32'd10, 6'b0, 32'd10, 32'd10, 32'd10, 32'd10, 32'd13, 32'd11},
        // R3: global freeze
        '{32'h1, 32'h1E021E02, 1'b0, 3'd4, 32'd7, 6'b0, 32'd7, 32'd7, 32'd7, 32'd7, 32'd7, 32'd7},
        // R3: low group freeze
        '{32'h2, 32'h1E021E02, 1'b0, 3'd2, 32'd0, 6'b0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd2, 32'd1},
        // R3: high group freeze
        '{32'h4, 32'h1E021E02, 1'b0, 3'd6, 32'd50, 6'b0, 32'd56, 32'd51, 32'd56, 32'd51, 32'd50, 32'd50},
        // R5 R6 R7: alternate codes, run latch low
        '{32'h0, 32'hFA1E55FE, 1'b0, 3'd7, 32'd0, 6'b0, 32'd7, 32'd0, 32'd1, 32'd0, 32'd7, 32'd1},
        // R7: run latch high
        '{32'h0, 32'hFA1E55FE, 1'b1, 3'd7, 32'd0, 6'b0, 32'd7, 32'd0, 32'd1, 32'd7, 32'd7, 32'd1},
        // R5 R6: counter 1 only accepts F0/FE
        '{32'h0, 32'h02F0FEF0, 1'b0, 3'd2, 32'd0, 6'b0, 32'd1, 32'd0, 32'd0, 32'd2, 32'd2, 32'd1},
        // R10 R11: counter 1 enable only
        '{32'h8, 32'h1E021E02, 1'b0, 3'd3, 32'h7FFFFFFE, 6'b000001, 32'h80000000, 32'h7FFFFFFF, 32'h80000001, 32'h7FFFFFFF, 32'h80000001, 32'h7FFFFFFF},
        // R10 R11: shared enable only
        '{32'h10, 32'h1E021E02, 1'b0, 3'd3, 32'h7FFFFFFE, 6'b010100, 32'h80000001, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF},
        // R10: exact threshold on all six
        '{32'h18, 32'h1E021E02, 1'b0, 3'd1, 32'h7FFFFFFF, 6'b111111, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000},
        // R11: wrap without enable
        '{32'h0, 32'h1E021E02, 1'b0, 3'd2, 32'hFFFFFFFF, 6'b0, 32'd1, 32'd0, 32'd1, 32'd0, 32'd1, 32'd0},
        // R9 R10: saturated, zero retired: only cycle counters re-flag
        '{32'h18, 32'h1E021E02, 1'b0, 3'd0, 32'h80000000, 6'b101010, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h80000000}
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int a, output logic [31:0] v);
        reg_addr = ADDR_W'(a);
        #0.2;
        v = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = ADDR_W'(a);
        reg_wdata = d;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] expv [6];

        // R1: state during reset
        repeat (2) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            read_reg(a, v);
            check32("R1 counter in reset", v, 32'h0);
        end
        read_reg(6, v); check32("R1 ctrl0 in reset", v, 32'h1);
        read_reg(7, v); check32("R1 ctrl1 in reset", v, 32'h0);
        check32("R1 ovf in reset", {31'h0, ovf_pulse}, 32'h0);

        // R1 R3: after release, still frozen while retiring
        rst_n = 1'b1;
        retired = 3'd5;
        repeat (4) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            read_reg(a, v);
            check32("R1 counter frozen after reset", v, 32'h0);
        end
        retired = '0;

        // table walk
        for (int n = 0; n < NV; n++) begin
            wr(6, 32'h1);
            wr(7, VECS[n].c1);
            for (int a = 0; a < 6; a++) wr(a, VECS[n].start);
            wr(6, VECS[n].c0);
            @(negedge clk);
            reg_we = 1'b0;
            retired = VECS[n].ret;
            run_latch = VECS[n].run;
            @(negedge clk);
            retired = '0;
            run_latch = 1'b0;
            expv[0] = VECS[n].e1; expv[1] = VECS[n].e2; expv[2] = VECS[n].e3;
            expv[3] = VECS[n].e4; expv[4] = VECS[n].e5; expv[5] = VECS[n].e6;
            for (int a = 0; a < 6; a++) begin
                read_reg(a, v);
                check32($sformatf("R2 R9 vector %0d counter %0d", n, a + 1), v, expv[a]);
            end
            check32($sformatf("R10 vector %0d ovf_vec", n), {26'h0, ovf_vec}, {26'h0, VECS[n].ovf});
            check32($sformatf("R10 vector %0d ovf_pulse", n), {31'h0, ovf_pulse}, {31'h0, |VECS[n].ovf});
        end

        // R12: write collides with increment next to the threshold
        wr(6, 32'h1);
        wr(7, 32'h1E021E02);
        for (int a = 0; a < 6; a++) wr(a, 32'h0);
        wr(6, 32'h10);
        retired = 3'd3;
        wr(4, 32'h7FFFFFFF);
        @(negedge clk);
        reg_we = 1'b0;
        read_reg(4, v);
        check32("R12 written value wins", v, 32'h7FFFFFFF);
        check32("R12 no overflow on write cycle", {26'h0, ovf_vec}, 32'h0);
        @(negedge clk);
        read_reg(4, v);
        check32("R10 saturates after write", v, 32'h80000000);
        check32("R10 flag after write", {26'h0, ovf_vec}, 32'h10);
        @(negedge clk);
        read_reg(4, v);
        check32("R10 holds at threshold", v, 32'h80000000);
        check32("R10 flag re-raised", {26'h0, ovf_vec}, 32'h10);
        retired = '0;
        read_reg(7, v);
        check32("R2 ctrl1 readback", v, 32'h1E021E02);
        read_reg(6, v);
        check32("R2 ctrl0 readback", v, 32'h10);

        finish_run();
    end
endmodule